// File: doc/BRIEF.md
# Voltage Setpoint Trim and Clamp

This block holds a signed output-voltage offset for a digitally controlled regulator and turns the selected setpoint into the code that drives the reference DAC. Software writes the offset as a 16-bit word. The block checks each write against a fixed mantissa window and acknowledges or rejects it. The accepted offset is added to either the nominal or the margin setpoint. The sum is limited first against the programmed upper and lower bounds, which raises a warning, and then against a hardware ceiling set by the loop scale, which raises nothing.

The DAC code then walks toward the clamped target one LSB at a time at a programmable pace. An 8-bit image of the offset, re-expressed at a fixed finer exponent, is offered for non-volatile storage. That image is read back in the first cycle after reset. All values share one output exponent, `VOUT_EXP` (default -9, so one LSB is 2^-9 V).

Top module: `vtc_top`

## Requirements
- R1: A write with a signed value from -127 to +127 is stored, pulses `wr_ack_o` in the cycle after the write, and is returned on `rd_data_o`.
- R2: A write outside -127..+127 pulses `wr_nack_o`, leaves the stored offset unchanged, and sets status bit 0 (invalid data).
- R3: `nvm_img_o` equals the offset multiplied by 2^(VOUT_EXP+12), saturated to -127..+127 in 8-bit two's complement. At the default this is the offset times 8.
- R4: In the first cycle after reset, the offset loads from `nvm_img_i` divided by 2^(VOUT_EXP+12), rounding toward minus infinity. At the default this is an arithmetic right shift by 3.
- R5: The sum is `vout_cmd_i` plus the offset when `margin_sel_i` is 0, and `vout_margin_i` plus the offset when it is 1. It is computed without overflow.
- R6: A sum above `vout_max_i` makes the target `vout_max_i` (subject to R8) and sets status bit 1 (limit warning).
- R7: A sum below `vout_min_i` makes the target `vout_min_i` (subject to R8) and sets status bit 1.
- R8: After R6 and R7, the target never exceeds a ceiling chosen by `scale_i`, and this clamp alone sets no status bit. The ceilings are 0.7 V, 1.4 V, 2.8 V and 6.0 V for `scale_i` = 0, 1, 2 and 3. At the default exponent these are codes 358, 716, 1433 and 3072.
- R9: `dac_code_o` moves by exactly one LSB toward `dac_target_o` once every N cycles. N is `rate_div_i`, and 0 is taken as 1. The code holds still once it equals the target.
- R10: Status bits are sticky. Each bit of `sts_clr_i` clears its bit, but a set in the same cycle wins. `alert_o` is high while any status bit is set.
- R11: While in reset, the status bits, `alert_o`, `wr_ack_o`, `wr_nack_o` and `dac_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Word write strobe |
| wr_data_i | input | 16 | Offset value to write, two's complement |
| rd_data_o | output | 16 | Stored offset |
| wr_ack_o | output | 1 | Write accepted (one-cycle pulse) |
| wr_nack_o | output | 1 | Write rejected (one-cycle pulse) |
| nvm_img_i | input | 8 | Stored backup image, read after reset |
| nvm_img_o | output | 8 | Backup image of the current offset |
| vout_cmd_i | input | 16 | Nominal setpoint code |
| vout_margin_i | input | 16 | Margin setpoint code |
| margin_sel_i | input | 1 | Select margin setpoint |
| vout_max_i | input | 16 | Upper limit code |
| vout_min_i | input | 16 | Lower limit code |
| scale_i | input | 2 | Loop scale: 0=1.0, 1=0.5, 2=0.25, 3=0.125 |
| rate_div_i | input | 8 | Cycles per ramp step |
| sts_clr_i | input | 2 | Per-bit status clear |
| sts_o | output | 2 | Bit 0 invalid data, bit 1 limit warning |
| alert_o | output | 1 | Any status bit set |
| dac_target_o | output | 16 | Clamped target code |
| dac_code_o | output | 16 | Ramped DAC code |

## Verification
The write path is swept over every value from -140 to +140. This separates acceptance from rejection at both window edges, and shows the backup image saturating wherever eight times the offset passes 127. The clamp is driven over a grid of every loop scale, both setpoint selections, offsets at the window extremes and near zero, and setpoints that land below the lower limit, inside the window, between the DAC ceiling and the upper limit, and above the upper limit. Comparing the target and the warning bit across that grid tells the silent ceiling clamp apart from the flagged limit clamp. Separate runs at two ramp rates and at rate zero confirm that the code walks toward the target rather than stepping to it. A reset with a negative image checks the floor rounding used when the offset is restored.

// File: rtl/vtc_pkg.sv
package vtc_pkg;

  typedef enum logic [1:0] {
    SC_FULL    = 2'd0,
    SC_HALF    = 2'd1,
    SC_QUARTER = 2'd2,
    SC_EIGHTH  = 2'd3
  } loop_scale_e;

  localparam int STATUS_BITS = 2;
  localparam int ST_INVALID  = 0;
  localparam int ST_LIMIT    = 1;

  // hardware ceiling in millivolts per loop scale
  function automatic int ceil_mv(input loop_scale_e sc);
    case (sc)
      SC_FULL:    return 700;
      SC_HALF:    return 1400;
      SC_QUARTER: return 2800;
      default:    return 6000;
    endcase
  endfunction

  // millivolts to code at exponent exp (exp < 0), truncating
  function automatic int mv_to_code(input int mv, input int exp);
    return (mv * (1 << (-exp))) / 1000;
  endfunction

endpackage

// File: rtl/vtc_trim_reg.sv
module vtc_trim_reg #(
  parameter int TW  = 16,
  parameter int NW  = 8,
  parameter int EXP = -9,
  parameter int LIM = 127
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [TW-1:0]        wr_data_i,
  input  logic [NW-1:0]        nvm_img_i,
  output logic signed [TW-1:0] trim_o,
  output logic [NW-1:0]        nvm_img_o,
  output logic                 ack_o,
  output logic                 nack_o
);
  localparam int SH     = EXP + 12;
  localparam int XW     = TW + NW + 1;
  localparam int NV_LIM = (1 << (NW - 1)) - 1;
  localparam logic signed [TW-1:0] LIM_HI = TW'(LIM);
  localparam logic signed [TW-1:0] LIM_LO = -LIM_HI;
  localparam logic signed [XW-1:0] NV_HI  = XW'(NV_LIM);
  localparam logic signed [XW-1:0] NV_LO  = -NV_HI;

  logic signed [TW-1:0] trim_q, restore_w, wr_s;
  logic signed [XW-1:0] trim_x, scaled_w;
  logic                 loaded_q, ack_q, nack_q, in_range;

  assign wr_s     = $signed(wr_data_i);
  assign in_range = (wr_s <= LIM_HI) && (wr_s >= LIM_LO);
  assign trim_x   = $signed({{(XW-TW){trim_q[TW-1]}}, trim_q});

  generate
    if (SH >= 0) begin : g_finer
      assign scaled_w  = trim_x <<< SH;
      assign restore_w = $signed({{(TW-NW){nvm_img_i[NW-1]}}, nvm_img_i}) >>> SH;
    end else begin : g_coarser
      assign scaled_w  = trim_x >>> (-SH);
      assign restore_w = $signed({{(TW-NW){nvm_img_i[NW-1]}}, nvm_img_i}) <<< (-SH);
    end
  endgenerate

  always_comb begin
    if (scaled_w > NV_HI)      nvm_img_o = NV_HI[NW-1:0];
    else if (scaled_w < NV_LO) nvm_img_o = NV_LO[NW-1:0];
    else                       nvm_img_o = scaled_w[NW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_q   <= '0;
      loaded_q <= 1'b0;
      ack_q    <= 1'b0;
      nack_q   <= 1'b0;
    end else begin
      ack_q  <= 1'b0;
      nack_q <= 1'b0;
      if (!loaded_q) begin
        trim_q   <= restore_w;
        loaded_q <= 1'b1;
      end else if (wr_en_i) begin
        if (in_range) begin
          trim_q <= wr_s;
          ack_q  <= 1'b1;
        end else begin
          nack_q <= 1'b1;
        end
      end
    end
  end

  assign trim_o = trim_q;
  assign ack_o  = ack_q;
  assign nack_o = nack_q;

  p_ack_in_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> (trim_q <= LIM_HI && trim_q >= LIM_LO));

  p_nack_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_q |-> (trim_q == $past(trim_q)));

  p_img_no_min_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nvm_img_o != {1'b1, {(NW-1){1'b0}}});

  p_ack_nack_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_q && nack_q));
endmodule

// File: rtl/vtc_clamp.sv
module vtc_clamp
  import vtc_pkg::*;
#(
  parameter int CW  = 16,
  parameter int TW  = 16,
  parameter int EXP = -9
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [TW-1:0] trim_i,
  input  logic [CW-1:0]        cmd_i,
  input  logic [CW-1:0]        margin_i,
  input  logic                 margin_sel_i,
  input  logic [CW-1:0]        max_i,
  input  logic [CW-1:0]        min_i,
  input  logic [1:0]           scale_i,
  output logic [CW-1:0]        tgt_o,
  output logic                 hit_o
);
  localparam int SW = CW + 2;

  logic [CW-1:0]        ceil_tab [4];
  logic [CW-1:0]        sp_w, lim_w, ceil_w, tgt_d, tgt_q;
  logic signed [SW-1:0] sum_w, max_w, min_w;
  logic                 over_w, under_w;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_ceil
      localparam int CODE = mv_to_code(ceil_mv(loop_scale_e'(g)), EXP);
      assign ceil_tab[g] = CW'(CODE);
    end
  endgenerate

  assign ceil_w  = ceil_tab[scale_i];
  assign sp_w    = margin_sel_i ? margin_i : cmd_i;
  assign sum_w   = $signed({2'b00, sp_w}) + $signed({{(SW-TW){trim_i[TW-1]}}, trim_i});
  assign max_w   = $signed({2'b00, max_i});
  assign min_w   = $signed({2'b00, min_i});
  assign over_w  = sum_w > max_w;
  assign under_w = !over_w && (sum_w < min_w);

  // limit clamp first (flagged), then DAC ceiling (silent)
  always_comb begin
    if (over_w)       lim_w = max_i;
    else if (under_w) lim_w = min_i;
    else              lim_w = sum_w[CW-1:0];
    tgt_d = (lim_w > ceil_w) ? ceil_w : lim_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgt_q <= '0;
    else         tgt_q <= tgt_d;
  end

  assign tgt_o = tgt_q;
  assign hit_o = over_w | under_w;

  p_under_ceiling_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_q <= $past(ceil_w));

  p_over_to_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_w && max_i <= ceil_w) |=> (tgt_q == $past(max_i)));

  p_under_to_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (under_w && min_i <= ceil_w) |=> (tgt_q == $past(min_i)));
endmodule

// File: rtl/vtc_ramp.sv
module vtc_ramp #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] tgt_i,
  input  logic [RW-1:0] rate_i,
  output logic [CW-1:0] code_o
);
  logic [RW-1:0] cnt_q, lim_w;
  logic [CW-1:0] code_q;

  assign lim_w = (rate_i == '0) ? '0 : rate_i - RW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (code_q == tgt_i) begin
      cnt_q <= '0;
    end else if (cnt_q >= lim_w) begin
      cnt_q  <= '0;
      code_q <= (code_q < tgt_i) ? code_q + CW'(1) : code_q - CW'(1);
    end else begin
      cnt_q <= cnt_q + RW'(1);
    end
  end

  assign code_o = code_q;

  p_single_lsb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |->
      (code_q == $past(code_q) + CW'(1) || code_q == $past(code_q) - CW'(1)));

  p_hold_at_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q == tgt_i) |=> (code_q == $past(code_q)));
endmodule

// File: rtl/vtc_top.sv
module vtc_top
  import vtc_pkg::*;
#(
  parameter int TW       = 16,
  parameter int CW       = 16,
  parameter int NW       = 8,
  parameter int RW       = 8,
  parameter int VOUT_EXP = -9,
  parameter int MANT_LIM = 127
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [TW-1:0]          wr_data_i,
  output logic [TW-1:0]          rd_data_o,
  output logic                   wr_ack_o,
  output logic                   wr_nack_o,
  input  logic [NW-1:0]          nvm_img_i,
  output logic [NW-1:0]          nvm_img_o,
  input  logic [CW-1:0]          vout_cmd_i,
  input  logic [CW-1:0]          vout_margin_i,
  input  logic                   margin_sel_i,
  input  logic [CW-1:0]          vout_max_i,
  input  logic [CW-1:0]          vout_min_i,
  input  logic [1:0]             scale_i,
  input  logic [RW-1:0]          rate_div_i,
  input  logic [STATUS_BITS-1:0] sts_clr_i,
  output logic [STATUS_BITS-1:0] sts_o,
  output logic                   alert_o,
  output logic [CW-1:0]          dac_target_o,
  output logic [CW-1:0]          dac_code_o
);
  logic signed [TW-1:0]   trim_w;
  logic                   nack_w, hit_w;
  logic [CW-1:0]          tgt_w;
  logic [STATUS_BITS-1:0] set_w, sts_q;

  vtc_trim_reg #(.TW(TW), .NW(NW), .EXP(VOUT_EXP), .LIM(MANT_LIM)) u_trim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .nvm_img_i (nvm_img_i),
    .trim_o    (trim_w),
    .nvm_img_o (nvm_img_o),
    .ack_o     (wr_ack_o),
    .nack_o    (nack_w)
  );

  vtc_clamp #(.CW(CW), .TW(TW), .EXP(VOUT_EXP)) u_clamp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trim_i       (trim_w),
    .cmd_i        (vout_cmd_i),
    .margin_i     (vout_margin_i),
    .margin_sel_i (margin_sel_i),
    .max_i        (vout_max_i),
    .min_i        (vout_min_i),
    .scale_i      (scale_i),
    .tgt_o        (tgt_w),
    .hit_o        (hit_w)
  );

  vtc_ramp #(.CW(CW), .RW(RW)) u_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tgt_i  (tgt_w),
    .rate_i (rate_div_i),
    .code_o (dac_code_o)
  );

  assign set_w[ST_INVALID] = nack_w;
  assign set_w[ST_LIMIT]   = hit_w;

  generate
    for (genvar b = 0; b < STATUS_BITS; b++) begin : g_sts
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sts_q[b] <= 1'b0;
        else         sts_q[b] <= set_w[b] | (sts_q[b] & ~sts_clr_i[b]);
      end

      p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_q[b] && !sts_clr_i[b]) |=> sts_q[b]);

      p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_w[b] |=> sts_q[b]);
    end
  endgenerate

  assign rd_data_o    = trim_w;
  assign wr_nack_o    = nack_w;
  assign sts_o        = sts_q;
  assign alert_o      = |sts_q;
  assign dac_target_o = tgt_w;
endmodule

// File: tb/sim_vtc_top.sv
module sim_vtc_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        ack, nack;
  logic [7:0]  img_in = 8'hEC;
  logic [7:0]  img_out;
  logic [15:0] cmd = '0, mrg = '0, vmax = 16'd3200, vmin = '0;
  logic        msel = 1'b0;
  logic [1:0]  scale = 2'd3;
  logic [7:0]  rate = 8'd1;
  logic [1:0]  clr = '0;
  logic [1:0]  sts;
  logic        alert;
  logic [15:0] tgt, code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vtc_top u0 (
    .clk_i (clk), .rst_ni (rst_ni), .wr_en_i (wr_en), .wr_data_i (wr_data),
    .rd_data_o (rd_data), .wr_ack_o (ack), .wr_nack_o (nack),
    .nvm_img_i (img_in), .nvm_img_o (img_out),
    .vout_cmd_i (cmd), .vout_margin_i (mrg), .margin_sel_i (msel),
    .vout_max_i (vmax), .vout_min_i (vmin), .scale_i (scale),
    .rate_div_i (rate), .sts_clr_i (clr), .sts_o (sts), .alert_o (alert),
    .dac_target_o (tgt), .dac_code_o (code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ceil_code(input int sc);
    int mv;
    mv = (sc == 0) ? 700 : (sc == 1) ? 1400 : (sc == 2) ? 2800 : 6000;
    return (mv * 512) / 1000;
  endfunction

  function automatic int sat127(input int v);
    return (v > 127) ? 127 : (v < -127) ? -127 : v;
  endfunction

  task automatic wr(input int v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_sts();
    @(negedge clk);
    clr = 2'b11;
    @(negedge clk);
    clr = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cur;
    int sps[8];
    int trs[5];
    sps = '{0, 100, 350, 700, 1430, 3000, 3100, 60000};
    trs = '{-127, -5, 0, 7, 127};

    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 sts", int'(sts), 0);
    chk("R11 alert", int'(alert), 0);
    chk("R11 ack", int'(ack), 0);
    chk("R11 nack", int'(nack), 0);
    chk("R11 code", int'(code), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R4 restore: -20 >>> 3 = -3; R3 image -24
    chk("R4 restore", int'($signed(rd_data)), -3);
    chk("R3 image after restore", int'($signed(img_out)), -24);
    cur = -3;

    // R1/R2/R3 sweep of written values
    for (int v = -140; v <= 140; v++) begin
      bit ok;
      ok = (v >= -127) && (v <= 127);
      wr(v);
      chk(ok ? "R1 ack" : "R2 ack", int'(ack), ok ? 1 : 0);
      chk(ok ? "R1 nack" : "R2 nack", int'(nack), ok ? 0 : 1);
      if (ok) cur = v;
      chk(ok ? "R1 readback" : "R2 unchanged", int'($signed(rd_data)), cur);
      chk("R3 image", int'($signed(img_out)), sat127(cur * 8));
      @(negedge clk);
      chk("R2 invalid bit", int'(sts[0]), ok ? 0 : 1);
      clear_sts();
    end

    // R5..R8 clamp grid
    for (int cfg = 0; cfg < 2; cfg++) begin
      vmax = (cfg == 0) ? 16'd3200 : 16'd500;
      vmin = (cfg == 0) ? 16'd50 : 16'd200;
      for (int sc = 0; sc < 4; sc++) begin
        for (int si = 0; si < 8; si++) begin
          for (int ti = 0; ti < 5; ti++) begin
            int sp, sum, r, e;
            bit hit;
            @(negedge clk);
            scale = 2'(sc);
            msel  = ((si + ti) % 2) == 1;
            cmd   = 16'(sps[si]);
            mrg   = 16'((sps[si] + 17) % 65536);
            sp    = msel ? (sps[si] + 17) % 65536 : sps[si];
            wr(trs[ti]);
            sum = sp + trs[ti];
            hit = (sum > int'(vmax)) || (sum < int'(vmin));
            r = (sum > int'(vmax)) ? int'(vmax) : (sum < int'(vmin)) ? int'(vmin) : sum;
            e = (r > ceil_code(sc)) ? ceil_code(sc) : r;
            repeat (2) @(negedge clk);
            clear_sts();
            repeat (2) @(negedge clk);
            chk(hit ? "R6/R7 target" : "R5/R8 target", int'(tgt), e);
            chk(hit ? "R6/R7 warn set" : "R8 silent", int'(sts[1]), hit ? 1 : 0);
            chk("R10 alert", int'(alert), hit ? 1 : 0);
          end
        end
      end
    end

    // R10 sticky after the condition goes away
    vmax = 16'd3200; vmin = 16'd0; scale = 2'd3; msel = 1'b0; cmd = 16'd3150;
    wr(100);
    repeat (3) @(negedge clk);
    chk("R6 warn", int'(sts[1]), 1);
    wr(0);
    repeat (3) @(negedge clk);
    chk("R10 sticky", int'(sts[1]), 1);
    chk("R10 alert sticky", int'(alert), 1);
    clear_sts();
    @(negedge clk);
    chk("R10 cleared", int'(sts), 0);
    chk("R10 alert low", int'(alert), 0);

    // R9 ramp
    cmd = 16'd300; rate = 8'd1;
    wr(0);
    repeat (400) @(negedge clk);
    chk("R9 settled", int'(code), 300);
    rate = 8'd4;
    wr(10);
    repeat (6) @(negedge clk);
    chk("R9 ramping not stepping", int'(code > 16'd300 && code < 16'd310), 1);
    repeat (60) @(negedge clk);
    chk("R9 reached", int'(code), 310);
    rate = 8'd0;
    wr(7);
    repeat (3) @(negedge clk);
    chk("R9 rate0 partial", int'(code < 16'd310 && code > 16'd307), 1);
    repeat (6) @(negedge clk);
    chk("R9 rate0 reached", int'(code), 307);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule